// File: doc/BRIEF.md
# Condition Register Logic Unit

This block holds a 32-bit condition register split into eight 4-bit fields and executes the small set of operations that act on it. A command bus with a valid flag, a 4-bit opcode, three 5-bit index operands and a 32-bit data operand selects one operation per cycle. The supported operations are a full-width write, a nibble copy between two fields, a transfer of the top four bits of a fixed-point exception register into a field, and eight single-bit boolean operations. Each boolean operation combines two source bits into one target bit.

Both the condition register and the exception register are always visible on output ports. Reading them back needs no command. A separate load port writes the exception register. Numbering is most-significant-first: bit index 0 is the MSB, and field 0 is the top nibble. Every accepted command takes effect on the next rising clock edge.

Top module: `cond_reg_unit`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) clears the condition register and the exception register to zero.
- R2: A write command (opcode 1) stores `cmd_data` in the condition register at the next edge, and `cr_out` then returns it unchanged (for example 0xAAAAAAAA and 0x55555555).
- R3: Bit index k names vector position 31-k, so bit 0 has weight 0x80000000 and bit 16 has weight 0x00008000. Field index f names the nibble whose most significant bit is bit index 4f, so field 0 is bits 31:28 and field 7 is bits 3:0.
- R4: A field copy (opcode 2) replaces the field named by `cmd_tgt[2:0]` with the field named by `cmd_srca[2:0]` and leaves the other seven fields unchanged. Copying field 0 onto field 4 turns 0x01234567 into 0x01230567; copying field 7 onto field 0 gives 0x71234567.
- R5: An exception transfer (opcode 3) copies bits 31:28 of the exception register, in order, into the field named by `cmd_tgt[2:0]`. It clears those four exception bits and leaves the lower 28 exception bits as they were.
- R6: When a transfer and an exception load occur in the same cycle, the transfer takes the old exception value, the new value is loaded in its low 28 bits, and its top four bits are forced to zero.
- R7: Opcodes 8 to 15 set target bit `cmd_tgt` to f(bit `cmd_srca`, bit `cmd_srcb`). In opcode order, f is AND, a AND NOT b, OR, a OR NOT b, XOR, NAND, NOR and XNOR. No other bit changes.
- R8: The target bit may be one of the source bits; the operation uses the source values from before the update.
- R9: With `cmd_valid` low, or with an undefined opcode (0, 4 to 7), the condition register holds its value.
- R10: `xer_ld` with no transfer in the same cycle stores `xer_din` in the exception register unchanged at the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 4 | Operation code |
| cmd_tgt | input | 5 | Target bit index; low 3 bits are the destination field |
| cmd_srca | input | 5 | First source bit index; low 3 bits are the source field |
| cmd_srcb | input | 5 | Second source bit index |
| cmd_data | input | 32 | Value for the write operation |
| xer_ld | input | 1 | Load the exception register |
| xer_din | input | 32 | Value to load into the exception register |
| cr_out | output | 32 | Current condition register |
| xer_out | output | 32 | Current exception register |

## Verification
The assertions assume that every input is driven to a known value from the first clock edge onward, with `cmd_valid` low or a defined command present. The only exception is that index operands not used by the current opcode may hold any value. The bench changes every input only on falling edges and keeps all inputs at zero during reset. It also places every index within its 5-bit or 3-bit range, so each antecedent always sees settled, defined operands.

// File: rtl/cond_reg_unit.sv
module cond_reg_unit #(
  parameter int FLD_W = 4,
  parameter int NFLD  = 8,
  localparam int CR_W   = FLD_W * NFLD,
  localparam int BIT_W  = $clog2(CR_W),
  localparam int FSEL_W = $clog2(NFLD),
  localparam int FW_LOG = $clog2(FLD_W)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_valid,
  input  logic [3:0]       cmd_op,
  input  logic [BIT_W-1:0] cmd_tgt,
  input  logic [BIT_W-1:0] cmd_srca,
  input  logic [BIT_W-1:0] cmd_srcb,
  input  logic [CR_W-1:0]  cmd_data,
  input  logic             xer_ld,
  input  logic [CR_W-1:0]  xer_din,
  output logic [CR_W-1:0]  cr_out,
  output logic [CR_W-1:0]  xer_out
);

  localparam logic [3:0] OP_WR  = 4'h1;
  localparam logic [3:0] OP_FCP = 4'h2;
  localparam logic [3:0] OP_XFR = 4'h3;

  logic [CR_W-1:0] cr_q, cr_d, xer_q, xer_d;
  logic            bit_a, bit_b, bit_r;

  // MSB-first numbering: index k lives at position (CR_W-1-k) = ~k
  wire [BIT_W-1:0] pos_t  = ~cmd_tgt;
  wire [BIT_W-1:0] pos_a  = ~cmd_srca;
  wire [BIT_W-1:0] pos_b  = ~cmd_srcb;
  wire [BIT_W-1:0] fpos_d = ~{cmd_tgt[FSEL_W-1:0], {FW_LOG{1'b0}}};
  wire [BIT_W-1:0] fpos_s = ~{cmd_srca[FSEL_W-1:0], {FW_LOG{1'b0}}};

  assign bit_a = cr_q[pos_a];
  assign bit_b = cr_q[pos_b];

  always_comb begin
    case (cmd_op[2:0])
      3'd0:    bit_r = bit_a & bit_b;
      3'd1:    bit_r = bit_a & ~bit_b;
      3'd2:    bit_r = bit_a | bit_b;
      3'd3:    bit_r = bit_a | ~bit_b;
      3'd4:    bit_r = bit_a ^ bit_b;
      3'd5:    bit_r = ~(bit_a & bit_b);
      3'd6:    bit_r = ~(bit_a | bit_b);
      default: bit_r = ~(bit_a ^ bit_b);
    endcase
  end

  always_comb begin
    cr_d  = cr_q;
    xer_d = xer_ld ? xer_din : xer_q;
    if (cmd_valid) begin
      case (cmd_op)
        OP_WR:  cr_d = cmd_data;
        OP_FCP: cr_d[fpos_d -: FLD_W] = cr_q[fpos_s -: FLD_W];
        OP_XFR: begin
          cr_d[fpos_d -: FLD_W] = xer_q[CR_W-1 -: FLD_W];
          xer_d[CR_W-1 -: FLD_W] = '0;
        end
        default: if (cmd_op[3]) cr_d[pos_t] = bit_r;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cr_q  <= '0;
      xer_q <= '0;
    end else begin
      cr_q  <= cr_d;
      xer_q <= xer_d;
    end
  end

  assign cr_out  = cr_q;
  assign xer_out = xer_q;

  function automatic logic [CR_W-1:0] fld_mask(input logic [FSEL_W-1:0] f);
    logic [CR_W-1:0] top;
    top = {{FLD_W{1'b1}}, {(CR_W-FLD_W){1'b0}}};
    return top >> {f, {FW_LOG{1'b0}}};
  endfunction

  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (cr_q == '0) && (xer_q == '0));

  p_write_value_r2: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_op == OP_WR) |=> cr_q == $past(cmd_data));

  p_copy_other_fields_r4: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_op == OP_FCP) |=>
      ((cr_q ^ $past(cr_q)) & ~fld_mask($past(cmd_tgt[FSEL_W-1:0]))) == '0);

  p_xfer_clears_top_r5: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_op == OP_XFR) |=> xer_q[CR_W-1 -: FLD_W] == '0);

  p_xfer_keeps_low_r5: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_op == OP_XFR && !xer_ld) |=>
      xer_q[CR_W-FLD_W-1:0] == $past(xer_q[CR_W-FLD_W-1:0]));

  p_bool_single_bit_r7: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_op[3]) |=> $countones(cr_q ^ $past(cr_q)) <= 1);

  p_idle_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (!cmd_valid) |=> $stable(cr_q));

  p_xer_load_r10: assert property (@(posedge clk) disable iff (rst)
    (xer_ld && !(cmd_valid && cmd_op == OP_XFR)) |=> xer_q == $past(xer_din));

endmodule

// File: tb/tb_cond_reg_unit.sv
module tb_cond_reg_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmd_valid = 1'b0;
  logic [3:0]  cmd_op = '0;
  logic [4:0]  cmd_tgt = '0, cmd_srca = '0, cmd_srcb = '0;
  logic [31:0] cmd_data = '0;
  logic        xer_ld = 1'b0;
  logic [31:0] xer_din = '0;
  logic [31:0] cr_out, xer_out;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  typedef struct {
    logic [31:0] cr;
    logic [31:0] xer;
    string       tag;
  } exp_t;
  exp_t sb[$];

  always #5 clk = ~clk;

  cond_reg_unit dut (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_tgt(cmd_tgt), .cmd_srca(cmd_srca), .cmd_srcb(cmd_srcb),
    .cmd_data(cmd_data), .xer_ld(xer_ld), .xer_din(xer_din),
    .cr_out(cr_out), .xer_out(xer_out)
  );

  task automatic compare(input exp_t e);
    checks++;
    if (cr_out !== e.cr || xer_out !== e.xer) begin
      failures++;
      $display("FAIL %s: cr=%08h xer=%08h expected cr=%08h xer=%08h",
               e.tag, cr_out, xer_out, e.cr, e.xer);
    end
  endtask

  // monitor: pops one expected item per falling edge
  initial forever begin
    @(negedge clk);
    if (sb.size() > 0) compare(sb.pop_front());
  end

  task automatic issue(input logic v, input logic [3:0] op, input logic [4:0] t,
                       input logic [4:0] a, input logic [4:0] b, input logic [31:0] d,
                       input logic ld, input logic [31:0] xd,
                       input logic [31:0] ecr, input logic [31:0] exer, input string tag);
    exp_t e;
    @(negedge clk);
    cmd_valid = v; cmd_op = op; cmd_tgt = t; cmd_srca = a; cmd_srcb = b;
    cmd_data = d; xer_ld = ld; xer_din = xd;
    @(posedge clk);
    e.cr = ecr; e.xer = exer; e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic wr(input logic [31:0] v, input logic [31:0] exer);
    issue(1, 4'h1, 0, 0, 0, v, 0, 0, v, exer, "R2 write");
  endtask

  task automatic bop(input logic [3:0] op, input logic [4:0] t, input logic [4:0] a,
                     input logic [4:0] b, input logic [31:0] ecr, input string tag);
    wr(32'h0000FFFF, 0);
    issue(1, op, t, a, b, 0, 0, 0, ecr, 0, tag);
  endtask

  function automatic logic bref(input int op, input logic a, input logic b);
    case (op)
      8: return a & b;
      9: return a & !b;
      10: return a | b;
      11: return a | !b;
      12: return a ^ b;
      13: return !(a & b);
      14: return !(a | b);
      default: return a == b;
    endcase
  endfunction

  initial begin
    repeat (2) @(posedge clk);
    @(negedge clk);
    compare('{cr: 32'h0, xer: 32'h0, tag: "R1 reset state"});
    rst = 1'b0;

    wr(32'hAAAAAAAA, 0);
    wr(32'h55555555, 0);

    // R3 numbering checked through bit 0 / bit 16 / bit 31 weights
    bop(4'h8, 0, 16, 17, 32'h8000FFFF, "R7 R3 AND 16,17->0");
    bop(4'h8, 0, 0, 16, 32'h0000FFFF, "R7 AND 0,16->0");
    bop(4'h9, 0, 16, 0, 32'h8000FFFF, "R7 ANDC 16,0->0");
    bop(4'hA, 0, 0, 1, 32'h0000FFFF, "R7 OR 0,1->0");
    bop(4'hB, 0, 0, 0, 32'h8000FFFF, "R8 ORC 0,0->0");
    bop(4'hC, 0, 0, 16, 32'h8000FFFF, "R7 XOR 0,16->0");
    bop(4'hD, 0, 16, 17, 32'h0000FFFF, "R7 NAND 16,17->0");
    bop(4'hE, 0, 0, 1, 32'h8000FFFF, "R7 NOR 0,1->0");
    bop(4'hF, 0, 0, 0, 32'h8000FFFF, "R8 EQV 0,0->0");
    bop(4'hC, 16, 16, 16, 32'h00007FFF, "R8 XOR self bit16");
    bop(4'hD, 31, 31, 31, 32'h0000FFFE, "R8 R3 NAND self bit31");
    for (int op = 8; op < 16; op++)
      bop(op[3:0], 0, 16, 0, 32'h0000FFFF | ({31'b0, bref(op, 1'b1, 1'b0)} << 31),
          "R7 sweep a=1 b=0");

    wr(32'h01234567, 0);
    issue(1, 4'h2, 4, 0, 0, 0, 0, 0, 32'h01230567, 0, "R4 copy f0->f4");
    wr(32'h01234567, 0);
    issue(1, 4'h2, 0, 7, 0, 0, 0, 0, 32'h71234567, 0, "R4 R3 copy f7->f0");

    wr(32'h0, 0);
    issue(0, 0, 0, 0, 0, 0, 1, 32'hA0000000, 32'h0, 32'hA0000000, "R10 xer load");
    issue(1, 4'h3, 1, 0, 0, 0, 0, 0, 32'h0A000000, 32'h0, "R5 xfer to f1");
    wr(32'h0, 0);
    issue(0, 0, 0, 0, 0, 0, 1, 32'h40000000, 32'h0, 32'h40000000, "R10 xer load");
    issue(1, 4'h3, 5, 0, 0, 0, 0, 0, 32'h00000400, 32'h0, "R5 xfer to f5");
    issue(0, 0, 0, 0, 0, 0, 1, 32'h50001234, 32'h00000400, 32'h50001234, "R10 xer load");
    issue(1, 4'h3, 7, 0, 0, 0, 0, 0, 32'h00000405, 32'h00001234, "R5 xfer keeps low bits");
    issue(0, 0, 0, 0, 0, 0, 1, 32'h90000000, 32'h00000405, 32'h90000000, "R10 xer load");
    issue(1, 4'h3, 2, 0, 0, 0, 1, 32'hF0000055, 32'h00900405, 32'h00000055, "R6 xfer+load");

    issue(0, 4'h1, 0, 0, 0, 32'hDEADBEEF, 0, 0, 32'h00900405, 32'h00000055, "R9 valid low");
    issue(1, 4'h5, 3, 4, 5, 32'hDEADBEEF, 0, 0, 32'h00900405, 32'h00000055, "R9 undefined op 5");
    issue(1, 4'h0, 3, 4, 5, 32'hDEADBEEF, 0, 0, 32'h00900405, 32'h00000055, "R9 undefined op 0");

    @(negedge clk);
    rst = 1'b1; cmd_valid = 0; cmd_op = 0; xer_ld = 0; cmd_data = 0;
    @(posedge clk);
    sb.push_back('{cr: 32'h0, xer: 32'h0, tag: "R1 reset mid-run"});
    @(negedge clk);
    rst = 1'b0;
    repeat (3) @(negedge clk);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule